// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block decides whether a conditional relative branch is taken and where execution continues. It also reports how many clock cycles the branch costs. Each request carries a 3-bit condition selector, four status flags (negative, overflow, zero, carry), the address of the instruction that follows the two-byte branch (the base address), and an 8-bit signed displacement.

The displacement is sign-extended and added to the base address, so the reach is -128 to +127 bytes. When the chosen flag matches the required value, the branch is taken and the sum becomes the next program counter. Otherwise the base address is passed through unchanged. The cycle count depends on two things: whether the branch is taken, and whether a taken target leaves the 256-byte page of the base address.

All results are registered and appear one clock after the request. The block has no flag outputs, so a branch can never change a status flag. Instruction fetch and the rest of the pipeline are outside this block.

Top module: `branch_eval_unit`

## Requirements
- R1: The selector names a flag in bits 2:1 (00 negative, 01 overflow, 10 carry, 11 zero) and the required flag value in bit 0. The branch is taken exactly when that flag equals that value.
- R2: For a taken branch, `target_pc` equals the base address plus the sign-extended displacement, modulo 2^16. Displacement 0x80 means -128 and 0x7F means +127.
- R3: For a not-taken branch, `target_pc` equals the base address, whatever the displacement.
- R4: A not-taken branch reports `cycles` = 2, even when the target it would have had lies in another page.
- R5: A taken branch whose target has the same upper 8 address bits as the base reports `cycles` = 3.
- R6: A taken branch whose target has different upper 8 bits from the base reports `cycles` = 4. This covers forward crossings, backward crossings and wrap-around past 0xFFFF.
- R7: A request with `in_valid` high gives `out_valid` high on the next clock, with its results. With `in_valid` low, `out_valid` is low on the next clock and `taken`, `target_pc` and `cycles` keep their values.
- R8: While `rst` is high, `out_valid`, `taken`, `target_pc` and `cycles` are cleared to zero on each clock, even if requests are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| cond_sel | input | 3 | Flag select in bits 2:1, required value in bit 0 |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| base_pc | input | 16 | Address of the instruction after the branch |
| disp | input | 8 | Signed displacement |
| out_valid | output | 1 | Result present |
| taken | output | 1 | Branch condition met |
| target_pc | output | 16 | Next program counter |
| cycles | output | 3 | Cycle cost of the branch (2, 3 or 4) |

## Verification
The condition decision and the page-cross detection are evaluated in the same cycle. The cycle count is only correct if the crossing is considered when the branch is taken and ignored when it is not. The bench provokes this overlap by pairing displacements that cross a page (forward, backward and around 0xFFFF) with flags that both satisfy and fail the condition. A scoreboard model predicts the taken flag, next address and cost of each request, and compares them with the result one clock later. The model also sweeps every selector against both flag values, with the other three flags set opposite, so that a wrongly chosen flag shows up.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int unsigned CYC_W = 3;

  typedef enum logic [1:0] {
    FLG_NEG = 2'b00,
    FLG_OVF = 2'b01,
    FLG_CRY = 2'b10,
    FLG_ZER = 2'b11
  } flag_sel_e;

  localparam logic [CYC_W-1:0] COST_SKIP = 3'd2;
  localparam logic [CYC_W-1:0] COST_NEAR = 3'd3;
  localparam logic [CYC_W-1:0] COST_FAR  = 3'd4;
endpackage

// File: rtl/brx_cond.sv
module brx_cond
  import brx_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             flag_n,
  input  logic             flag_v,
  input  logic             flag_z,
  input  logic             flag_c,
  output logic             take
);
  localparam int unsigned NUM_COND = 1 << SEL_W;
  localparam int unsigned NUM_FLAG = NUM_COND / 2;

  logic [NUM_FLAG-1:0] flag_vec;
  logic [NUM_COND-1:0] hit;

  always_comb begin
    flag_vec = '0;
    flag_vec[FLG_NEG] = flag_n;
    flag_vec[FLG_OVF] = flag_v;
    flag_vec[FLG_CRY] = flag_c;
    flag_vec[FLG_ZER] = flag_z;
  end

  // One match term per selector code: flag index is code/2, wanted value is code[0].
  for (genvar k = 0; k < NUM_COND; k++) begin : g_term
    localparam logic [SEL_W-1:0] CODE = SEL_W'(k);
    assign hit[k] = (sel == CODE) && (flag_vec[k/2] == CODE[0]);
  end

  assign take = |hit;
endmodule

// File: rtl/brx_target.sv
module brx_target #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned PAGE_W = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] target,
  output logic              far
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign target   = base + disp_ext;
  assign far      = target[ADDR_W-1:PAGE_W] != base[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/brx_cost.sv
module brx_cost
  import brx_pkg::*;
(
  input  logic             take,
  input  logic             far,
  output logic [CYC_W-1:0] cost
);
  always_comb begin
    if (!take)    cost = COST_SKIP;
    else if (far) cost = COST_FAR;
    else          cost = COST_NEAR;
  end
endmodule

// File: rtl/branch_eval_unit.sv
module branch_eval_unit
  import brx_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic              flag_n,
  input  logic              flag_v,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic [ADDR_W-1:0] base_pc,
  input  logic [DISP_W-1:0] disp,
  output logic              out_valid,
  output logic              taken,
  output logic [ADDR_W-1:0] target_pc,
  output logic [CYC_W-1:0]  cycles
);
  logic              take_c;
  logic              far_c;
  logic [ADDR_W-1:0] sum_c;
  logic [CYC_W-1:0]  cost_c;

  brx_cond #(.SEL_W(SEL_W)) cond_i (
    .sel    (cond_sel),
    .flag_n (flag_n),
    .flag_v (flag_v),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .take   (take_c)
  );

  brx_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .PAGE_W(PAGE_W)) tgt_i (
    .base   (base_pc),
    .disp   (disp),
    .target (sum_c),
    .far    (far_c)
  );

  brx_cost cost_i (
    .take (take_c),
    .far  (far_c),
    .cost (cost_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      target_pc <= '0;
      cycles    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken     <= take_c;
        target_pc <= take_c ? sum_c : base_pc;
        cycles    <= cost_c;
      end
    end
  end
endmodule

// File: rtl/branch_eval_unit_chk.sv
module branch_eval_unit_chk
  import brx_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [SEL_W-1:0]  cond_sel,
  input logic              flag_z,
  input logic [ADDR_W-1:0] base_pc,
  input logic              out_valid,
  input logic              taken,
  input logic [ADDR_W-1:0] target_pc,
  input logic [CYC_W-1:0]  cycles
);
  // R1: selector 111 with zero flag set must yield a taken result
  assert_zero_set_taken_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_sel == 3'b111 && flag_z) |=> taken);

  // R3: a not-taken result keeps the base address
  assert_skip_keeps_base_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid) |=> (taken || target_pc == $past(base_pc)));

  // R4: a not-taken result costs two cycles
  assert_skip_cost_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !taken) |-> (cycles == COST_SKIP));

  // R5: taken inside the page costs three cycles
  assert_near_cost_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid) |=> (!taken ||
      target_pc[ADDR_W-1:PAGE_W] != $past(base_pc[ADDR_W-1:PAGE_W]) ||
      cycles == COST_NEAR));

  // R6: taken across a page costs four cycles
  assert_far_cost_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid) |=> (!taken ||
      target_pc[ADDR_W-1:PAGE_W] == $past(base_pc[ADDR_W-1:PAGE_W]) ||
      cycles == COST_FAR));

  // R7: valid follows the request by one clock, results hold when idle
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(target_pc) && $stable(cycles) && $stable(taken)));

  // R8: reset clears the outputs
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && !taken && target_pc == '0 && cycles == '0));
endmodule

bind branch_eval_unit branch_eval_unit_chk #(
  .ADDR_W(ADDR_W), .DISP_W(DISP_W), .PAGE_W(PAGE_W), .SEL_W(SEL_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .cond_sel  (cond_sel),
  .flag_z    (flag_z),
  .base_pc   (base_pc),
  .out_valid (out_valid),
  .taken     (taken),
  .target_pc (target_pc),
  .cycles    (cycles)
);

// File: tb/branch_eval_unit_tb_top.sv
module branch_eval_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  cond_sel;
  logic        flag_n, flag_v, flag_z, flag_c;
  logic [15:0] base_pc;
  logic [7:0]  disp;
  logic        out_valid;
  logic        taken;
  logic [15:0] target_pc;
  logic [2:0]  cycles;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic        tk;
    logic [15:0] pc;
    logic [2:0]  cyc;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  logic [15:0] last_pc;
  logic [2:0]  last_cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_eval_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cond_sel(cond_sel),
    .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
    .base_pc(base_pc), .disp(disp), .out_valid(out_valid), .taken(taken),
    .target_pc(target_pc), .cycles(cycles)
  );

  task automatic note(input bit ok, input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: present one request and push the predicted result.
  task automatic send(input logic [2:0] s, input logic n, input logic v,
                      input logic z, input logic c, input logic [15:0] b,
                      input logic [7:0] d, input string tag);
    exp_t e;
    logic fl;
    logic [15:0] sum;
    @(negedge clk);
    in_valid = 1'b1; cond_sel = s;
    flag_n = n; flag_v = v; flag_z = z; flag_c = c;
    base_pc = b; disp = d;
    case (s[2:1])
      2'b00:   fl = n;
      2'b01:   fl = v;
      2'b10:   fl = c;
      default: fl = z;
    endcase
    e.tk = (fl == s[0]);
    sum  = b + {{8{d[7]}}, d};
    e.pc = e.tk ? sum : b;
    if (!e.tk)                   e.cyc = 3'd2;
    else if (sum[15:8] != b[15:8]) e.cyc = 3'd4;
    else                         e.cyc = 3'd3;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compare each produced result with the oldest prediction.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb_q.size() == 0) begin
        note(1'b0, "R7", "unexpected result", 16'(out_valid), 16'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        note(taken == e.tk, e.tag, "taken", 16'(taken), 16'(e.tk));
        note(target_pc == e.pc, e.tag, "target_pc", target_pc, e.pc);
        note(cycles == e.cyc, e.tag, "cycles", 16'(cycles), 16'(e.cyc));
        last_pc  = e.pc;
        last_cyc = e.cyc;
      end
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; cond_sel = 3'b111;
    flag_n = 1'b1; flag_v = 1'b1; flag_z = 1'b1; flag_c = 1'b1;
    base_pc = 16'h1234; disp = 8'h10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset dominates a pending request
    note(out_valid == 1'b0, "R8", "out_valid in reset", 16'(out_valid), 16'd0);
    note(taken == 1'b0, "R8", "taken in reset", 16'(taken), 16'd0);
    note(target_pc == 16'h0, "R8", "target_pc in reset", target_pc, 16'h0);
    note(cycles == 3'd0, "R8", "cycles in reset", 16'(cycles), 16'd0);
    in_valid = 1'b0;
    rst = 1'b0;

    send(3'b000, 0, 1, 1, 1, 16'h2010, 8'h05, "R1 R2 R5 negative clear");
    send(3'b001, 0, 1, 1, 1, 16'h2010, 8'h05, "R3 R4 negative not set");
    send(3'b011, 0, 1, 0, 0, 16'h3080, 8'h80, "R2 R5 minus 128");
    send(3'b010, 1, 0, 1, 1, 16'h30FF, 8'h7F, "R2 R6 forward cross");
    send(3'b100, 1, 1, 1, 0, 16'h4000, 8'hFF, "R6 backward cross");
    send(3'b101, 1, 1, 1, 0, 16'h40F0, 8'h7F, "R4 skip despite cross");
    send(3'b110, 1, 1, 0, 1, 16'hFFFE, 8'h05, "R6 wrap past top");
    send(3'b111, 0, 0, 1, 0, 16'h5055, 8'h00, "R5 zero displacement");
    send(3'b111, 1, 1, 0, 1, 16'h5055, 8'h20, "R3 zero not set");

    // R7: an idle cycle drops out_valid and holds the last results
    idle();
    @(negedge clk);
    note(out_valid == 1'b0, "R7", "out_valid idle", 16'(out_valid), 16'd0);
    note(target_pc == last_pc, "R7", "target_pc hold", target_pc, last_pc);
    note(cycles == last_cyc, "R7", "cycles hold", 16'(cycles), 16'(last_cyc));

    // R1: every selector against both values of its flag, other flags opposite
    for (int s = 0; s < 8; s++) begin
      for (int f = 0; f < 2; f++) begin
        logic fv;
        logic n, v, z, c;
        fv = f[0];
        n = ~fv; v = ~fv; z = ~fv; c = ~fv;
        case (s / 2)
          0:       n = fv;
          1:       v = fv;
          2:       c = fv;
          default: z = fv;
        endcase
        send(3'(s), n, v, z, c, 16'h6000 + 16'(s * 16), 8'h08, "R1 selector sweep");
      end
    end
    idle();
    repeat (3) @(negedge clk);
    note(sb_q.size() == 0, "R7", "results outstanding", 16'(sb_q.size()), 16'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule